// File: doc/BRIEF.md
# Register Alias Table Renamer

This block is the rename map at the front of an out-of-order core that retires results into a retirement register file. The file holds one physical register for each architectural register. For each architectural register the table holds a valid bit and a reorder-buffer tag. When the valid bit is clear, the current value of that register lives in the retirement file. When it is set, the value will come from the reorder-buffer entry named by the tag.

Every cycle up to `SLOTS` operations are renamed in program order. For each one, the block reports for both source registers whether the operand is in the reorder buffer and, if so, the producer's entry index. It then records the operation's destination register as mapped to its newly allocated reorder-buffer entry.

When an entry commits, the block clears the committed register's mapping, but only if that mapping still names the committing entry. A flush, for example after a mispredicted branch, returns every register to the retirement file in one cycle. Value storage and the reorder buffer itself lie outside this block.

Top module: `rat_renamer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every source lookup reports the retirement file (`InRob` = 0) for all eight registers.
- R2: A lookup of an unmapped register gives `InRob` = 0. A lookup of a mapped register gives `InRob` = 1 and the tag of the latest producer recorded for that register.
- R3: A rename with `renValid` and `dstValid` both set maps `dstReg` to `dstTag`. Lookups see the new mapping from the next cycle on.
- R4: A commit of tag T for register R returns R to the retirement file from the next cycle, provided R was mapped to T.
- R5: A commit whose tag differs from the current mapping of its register, or whose register is unmapped, leaves the table unchanged.
- R6: A flush clears every mapping in one cycle. Renames and commits presented in the same cycle as the flush are discarded.
- R7: The source lookups of an operation see the table as it was before that operation's own destination write, so a source equal to the operation's own destination reports the older producer.
- R8: Slot k's sources see the destinations of slots 0..k-1 of the same cycle, and the highest such slot wins. When two slots write the same register, the higher slot's tag is the one kept.
- R9: When a rename and a matching commit name the same register in the same cycle, the rename wins and the register stays mapped to the new tag. Lookups made in a commit cycle still see the mapping that existed before the commit.
- R10: An operation with `renValid` low, or with `dstValid` low, changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | SLOTS | Slot k carries a valid operation |
| srcA | input | SLOTS*REG_W | First source register of each slot |
| srcB | input | SLOTS*REG_W | Second source register of each slot |
| dstValid | input | SLOTS | Slot k writes a destination |
| dstReg | input | SLOTS*REG_W | Destination register of each slot |
| dstTag | input | SLOTS*TAG_W | Reorder-buffer entry allocated to each slot |
| commitValid | input | 1 | A reorder-buffer entry retires this cycle |
| commitReg | input | REG_W | Destination register of the retiring entry |
| commitTag | input | TAG_W | Index of the retiring entry |
| flush | input | 1 | Revert all registers to the retirement file |
| srcAInRob | output | SLOTS | First source of slot k comes from the reorder buffer |
| srcATag | output | SLOTS*TAG_W | Producer entry for the first source |
| srcBInRob | output | SLOTS | Second source of slot k comes from the reorder buffer |
| srcBTag | output | SLOTS*TAG_W | Producer entry for the second source |

## Verification
A corrupt table entry cannot hide for long. It shows at the lookup ports as a wrong `InRob` flag or a wrong tag in the first cycle that any slot reads that register. A clear that was lost, or a clear applied to a stale tag, shows one cycle after the commit. The bench keeps its own map and checks every source of every slot on every cycle. Directed sequences aim at the same-cycle orderings (own destination, earlier slot, rename against commit, flush against rename), and a long random phase mixes renames, commits that match or are stale, and flushes.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int ARCH_REGS = 8;
  localparam int TAG_W     = 6;
  localparam int SLOTS     = 2;
  localparam int REG_W     = $clog2(ARCH_REGS);
  localparam int OPS       = 2 * SLOTS;

  typedef logic [REG_W-1:0] archReg_t;
  typedef logic [TAG_W-1:0] robTag_t;

  typedef struct packed {
    logic                               flushAll;
    logic [ARCH_REGS-1:0]               wrEn;
    logic [ARCH_REGS-1:0][TAG_W-1:0]    wrTag;
    logic [ARCH_REGS-1:0]               clrEn;
  } ratStrobe_t;
endpackage

// File: rtl/rat_ctrl.sv
module rat_ctrl
  import rat_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SLOTS-1:0]            renValid,
  input  logic [SLOTS-1:0]            dstValid,
  input  logic [SLOTS*REG_W-1:0]      dstReg,
  input  logic [SLOTS*TAG_W-1:0]      dstTag,
  input  logic                        commitValid,
  input  archReg_t                    commitReg,
  input  robTag_t                     commitTag,
  input  logic                        flush,
  input  logic [ARCH_REGS-1:0]        curValid,
  input  logic [ARCH_REGS*TAG_W-1:0]  curTag,
  output ratStrobe_t                  strb
);

  // Per-register write and clear strobes; a higher slot overrides a lower one.
  always_comb begin
    strb          = '0;
    strb.flushAll = flush;
    for (int r = 0; r < ARCH_REGS; r++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (renValid[s] && dstValid[s] &&
            dstReg[s*REG_W +: REG_W] == REG_W'(r)) begin
          strb.wrEn[r]  = 1'b1;
          strb.wrTag[r] = dstTag[s*TAG_W +: TAG_W];
        end
      end
      strb.clrEn[r] = commitValid && (commitReg == REG_W'(r)) && curValid[r] &&
                      (curTag[r*TAG_W +: TAG_W] == commitTag) && !strb.wrEn[r];
    end
  end

  for (genvar r = 0; r < ARCH_REGS; r++) begin : gChk
    logic commitHit;
    assign commitHit = commitValid && (commitReg == REG_W'(r)) &&
                       (curTag[r*TAG_W +: TAG_W] == commitTag);

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (commitHit && curValid[r] && !flush && !strb.wrEn[r]) |=> !curValid[r]); // R4

    AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      (curValid[r] && !flush && !commitHit) |=> curValid[r]); // R5
  end

endmodule

// File: rtl/rat_datapath.sv
module rat_datapath
  import rat_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ratStrobe_t                  strb,
  input  logic [SLOTS-1:0]            renValid,
  input  logic [SLOTS*REG_W-1:0]      srcA,
  input  logic [SLOTS*REG_W-1:0]      srcB,
  input  logic [SLOTS-1:0]            dstValid,
  input  logic [SLOTS*REG_W-1:0]      dstReg,
  input  logic [SLOTS*TAG_W-1:0]      dstTag,
  output logic [ARCH_REGS-1:0]        curValid,
  output logic [ARCH_REGS*TAG_W-1:0]  curTag,
  output logic [SLOTS-1:0]            srcAInRob,
  output logic [SLOTS*TAG_W-1:0]      srcATag,
  output logic [SLOTS-1:0]            srcBInRob,
  output logic [SLOTS*TAG_W-1:0]      srcBTag
);

  logic [ARCH_REGS-1:0]            validQ;
  logic [ARCH_REGS-1:0][TAG_W-1:0] tagQ;

  always_ff @(posedge clk) begin
    if (!rstN || strb.flushAll) begin
      validQ <= '0;
      if (!rstN) tagQ <= '0;
    end else begin
      for (int r = 0; r < ARCH_REGS; r++) begin
        if (strb.wrEn[r]) begin
          validQ[r] <= 1'b1;
          tagQ[r]   <= strb.wrTag[r];
        end else if (strb.clrEn[r]) begin
          validQ[r] <= 1'b0;
        end
      end
    end
  end

  assign curValid = validQ;
  assign curTag   = tagQ;

  // Operand k: first sources occupy 0..SLOTS-1, second sources SLOTS..OPS-1.
  logic [OPS-1:0][REG_W-1:0] opReg;
  logic [OPS-1:0]            opIn;
  logic [OPS-1:0][TAG_W-1:0] opTag;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      opReg[s]         = srcA[s*REG_W +: REG_W];
      opReg[SLOTS + s] = srcB[s*REG_W +: REG_W];
    end
  end

  for (genvar k = 0; k < OPS; k++) begin : gLook
    localparam int SLOT = k % SLOTS;
    always_comb begin
      opIn[k]  = validQ[opReg[k]];
      opTag[k] = tagQ[opReg[k]];
      for (int e = 0; e < SLOT; e++) begin
        if (renValid[e] && dstValid[e] && dstReg[e*REG_W +: REG_W] == opReg[k]) begin
          opIn[k]  = 1'b1;
          opTag[k] = dstTag[e*TAG_W +: TAG_W];
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      srcAInRob[s]             = opIn[s];
      srcATag[s*TAG_W +: TAG_W] = opTag[s];
      srcBInRob[s]             = opIn[SLOTS + s];
      srcBTag[s*TAG_W +: TAG_W] = opTag[SLOTS + s];
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |=> (validQ == '0)); // R6

  for (genvar r = 0; r < ARCH_REGS; r++) begin : gWrChk
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (strb.wrEn[r] && !strb.flushAll) |=> (validQ[r] && tagQ[r] == $past(strb.wrTag[r]))); // R3
  end

endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
  import rat_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SLOTS-1:0]            renValid,
  input  logic [SLOTS*REG_W-1:0]      srcA,
  input  logic [SLOTS*REG_W-1:0]      srcB,
  input  logic [SLOTS-1:0]            dstValid,
  input  logic [SLOTS*REG_W-1:0]      dstReg,
  input  logic [SLOTS*TAG_W-1:0]      dstTag,
  input  logic                        commitValid,
  input  logic [REG_W-1:0]            commitReg,
  input  logic [TAG_W-1:0]            commitTag,
  input  logic                        flush,
  output logic [SLOTS-1:0]            srcAInRob,
  output logic [SLOTS*TAG_W-1:0]      srcATag,
  output logic [SLOTS-1:0]            srcBInRob,
  output logic [SLOTS*TAG_W-1:0]      srcBTag
);

  ratStrobe_t                 strb;
  logic [ARCH_REGS-1:0]       curValid;
  logic [ARCH_REGS*TAG_W-1:0] curTag;

  rat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .dstValid(dstValid),
    .dstReg(dstReg), .dstTag(dstTag), .commitValid(commitValid),
    .commitReg(commitReg), .commitTag(commitTag), .flush(flush),
    .curValid(curValid), .curTag(curTag), .strb(strb)
  );

  rat_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .renValid(renValid),
    .srcA(srcA), .srcB(srcB), .dstValid(dstValid), .dstReg(dstReg),
    .dstTag(dstTag), .curValid(curValid), .curTag(curTag),
    .srcAInRob(srcAInRob), .srcATag(srcATag),
    .srcBInRob(srcBInRob), .srcBTag(srcBTag)
  );

endmodule

// File: tb/rat_renamer_test.sv
module rat_renamer_test;
  import rat_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic                   clk = 1'b0;
  logic                   rstN;
  logic [SLOTS-1:0]       renValid, dstValid, srcAInRob, srcBInRob;
  logic [SLOTS*REG_W-1:0] srcA, srcB, dstReg;
  logic [SLOTS*TAG_W-1:0] dstTag, srcATag, srcBTag;
  logic                   commitValid, flush;
  logic [REG_W-1:0]       commitReg;
  logic [TAG_W-1:0]       commitTag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;
  string req = "R1";

  logic            mValid [ARCH_REGS];
  logic [TAG_W-1:0] mTag  [ARCH_REGS];

  always #(CLK_PERIOD/2) clk = ~clk;

  rat_renamer uut (
    .clk(clk), .rstN(rstN), .renValid(renValid), .srcA(srcA), .srcB(srcB),
    .dstValid(dstValid), .dstReg(dstReg), .dstTag(dstTag),
    .commitValid(commitValid), .commitReg(commitReg), .commitTag(commitTag),
    .flush(flush), .srcAInRob(srcAInRob), .srcATag(srcATag),
    .srcBInRob(srcBInRob), .srcBTag(srcBTag)
  );

  task automatic idleIn();
    renValid = '0; dstValid = '0; dstReg = '0; dstTag = '0;
    srcA = '0; srcB = '0; commitValid = 0; commitReg = '0; commitTag = '0; flush = 0;
  endtask

  task automatic setOp(int s, bit ren, bit dv, int dr, int dt, int sa, int sb);
    renValid[s] = ren; dstValid[s] = dv;
    dstReg[s*REG_W +: REG_W] = REG_W'(dr);
    dstTag[s*TAG_W +: TAG_W] = TAG_W'(dt);
    srcA[s*REG_W +: REG_W]   = REG_W'(sa);
    srcB[s*REG_W +: REG_W]   = REG_W'(sb);
  endtask

  // Compare all lookups against the model, then advance the model as the edge will.
  task automatic step();
    #1;
    for (int s = 0; s < SLOTS; s++) begin
      for (int op = 0; op < 2; op++) begin
        int x;
        logic ev, ai;
        logic [TAG_W-1:0] et, at;
        x  = op ? int'(srcB[s*REG_W +: REG_W]) : int'(srcA[s*REG_W +: REG_W]);
        ev = rstN ? mValid[x] : 1'b0;
        et = mTag[x];
        if (rstN) begin
          for (int e = 0; e < s; e++) begin
            if (renValid[e] && dstValid[e] && int'(dstReg[e*REG_W +: REG_W]) == x) begin
              ev = 1'b1; et = dstTag[e*TAG_W +: TAG_W];
            end
          end
        end
        ai = op ? srcBInRob[s] : srcAInRob[s];
        at = op ? srcBTag[s*TAG_W +: TAG_W] : srcATag[s*TAG_W +: TAG_W];
        checks++;
        if (ai !== ev || (ev && at !== et)) begin
          errors++;
          $display("FAIL %s cycle %0d slot %0d src%0d reg %0d: got inRob=%b tag=%0d, expected inRob=%b tag=%0d",
                   req, cycles, s, op, x, ai, at, ev, et);
        end
      end
    end
    if (!rstN || flush) begin
      for (int r = 0; r < ARCH_REGS; r++) mValid[r] = 1'b0;
    end else begin
      if (commitValid && mValid[commitReg] && mTag[commitReg] == commitTag)
        mValid[commitReg] = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        if (renValid[s] && dstValid[s]) begin
          mValid[dstReg[s*REG_W +: REG_W]] = 1'b1;
          mTag[dstReg[s*REG_W +: REG_W]]   = dstTag[s*TAG_W +: TAG_W];
        end
      end
    end
    @(negedge clk);
    cycles++;
  endtask

  // Two cycles of pure lookups covering every register.
  task automatic observe();
    for (int c = 0; c < 2; c++) begin
      idleIn();
      for (int s = 0; s < SLOTS; s++) setOp(s, 0, 0, 0, 0, c*4 + s*2, c*4 + s*2 + 1);
      step();
    end
  endtask

  initial begin
    for (int r = 0; r < ARCH_REGS; r++) begin mValid[r] = 0; mTag[r] = '0; end
    rstN = 0;
    idleIn();
    @(negedge clk);
    req = "R1";
    observe();
    rstN = 1;
    observe();

    req = "R3";
    idleIn(); setOp(0, 1, 1, 1, 5, 0, 0); step();
    observe();

    req = "R7";
    idleIn(); setOp(0, 1, 1, 1, 6, 1, 1); step();
    observe();

    req = "R8";
    idleIn(); setOp(0, 1, 1, 3, 7, 0, 0); setOp(1, 1, 1, 0, 0, 3, 1); dstValid[1] = 0; step();
    idleIn(); setOp(0, 1, 1, 4, 8, 4, 4); setOp(1, 1, 1, 4, 9, 4, 3); step();
    observe();

    req = "R4";
    idleIn(); commitValid = 1; commitReg = 1; commitTag = 6; step();
    observe();

    req = "R5";
    idleIn(); setOp(0, 1, 1, 3, 10, 3, 3); step();
    idleIn(); commitValid = 1; commitReg = 3; commitTag = 7; step();
    idleIn(); commitValid = 1; commitReg = 1; commitTag = 6; step();
    observe();

    req = "R9";
    idleIn(); commitValid = 1; commitReg = 3; commitTag = 10;
    setOp(0, 1, 1, 3, 11, 3, 3); step();
    idleIn(); commitValid = 1; commitReg = 4; commitTag = 9; setOp(0, 0, 0, 0, 0, 4, 4); step();
    observe();

    req = "R10";
    idleIn(); setOp(0, 0, 1, 5, 12, 5, 5); setOp(1, 1, 0, 6, 13, 5, 6); step();
    observe();

    req = "R6";
    idleIn(); setOp(0, 1, 1, 2, 14, 2, 3); setOp(1, 1, 1, 7, 15, 7, 2);
    commitValid = 1; commitReg = 3; commitTag = 11; flush = 1; step();
    observe();

    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      int cr;
      idleIn();
      for (int s = 0; s < SLOTS; s++)
        setOp(s, ($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % ARCH_REGS,
              $urandom % (1 << TAG_W), $urandom % ARCH_REGS, $urandom % ARCH_REGS);
      cr = $urandom % ARCH_REGS;
      commitValid = ($urandom % 2) != 0;
      commitReg   = REG_W'(cr);
      commitTag   = ($urandom % 3 != 0) ? mTag[cr] : TAG_W'($urandom);
      flush       = ($urandom % 60) == 0;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule